// File: doc/BRIEF.md
# Interrupt Request Aggregator

This block collects thirty-two interrupt request lines into one summary word, reachable over a simple 32-bit register port, and drives a single interrupt output towards the processor. Each line has three settings held in registers: an enable bit, a choice between level and edge sensing, and an active polarity. Every input passes through a two-stage synchronizer before it is conditioned.

Lines 0 to 19 carry slot interrupts. Line 31 carries a cascaded interrupt from a legacy bus controller, and at reset it is the only line set to active-high. Lines 20 to 30 are not connected and never report a request. A board-variant parameter chooses which summary bits may be reported at all.

Edge-mode requests stay latched until software dismisses them. To dismiss a request, software writes a 1 to that line's bit in the clear register and then writes 0 to the clear register. A keyed write to the reset register raises a one-cycle system reset request.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the enable register reads 0, the mode register reads 0 (all lines level), the polarity register reads 0x80000000, the clear register reads 0, and irq_o is low.
- R2: Register word addresses are: 0 enable, 1 mode, 2 polarity, 3 clear, 4 summary (read-only), 5 reset (write-only). The enable, mode, polarity and clear registers read back the value last written to them. In the enable register 1 enables a line. In the mode register 1 selects edge sensing. In the polarity register 1 makes a line active-high.
- R3: For a line in level mode, its summary bit is 1 exactly when its input equals its polarity bit. The summary follows an input that has been stable for at least three clocks.
- R4: For a line in edge mode, a transition into the active level sets the summary bit. The bit stays set after the input returns to the inactive level.
- R5: A latched edge request is cleared only after a 1 has been written to its clear bit and then 0 has been written to the clear register. It stays set while the clear bit still holds 1.
- R6: For a level-mode line whose input stays active, the clear sequence leaves the summary bit at 1.
- R7: Summary bits 20 to 30 always read 0, whatever their inputs are. With the default board variant, bits 0 to 19 and bit 31 are reportable.
- R8: irq_o is high exactly when the summary AND the enable register is non-zero.
- R9: Writing 0x0000DEAD to the reset register makes reset_req_o high for exactly one cycle. Writing any other value produces no pulse.
- R10: A write to the summary address changes nothing that can be read. The reset register reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| req_i | input | 32 | Raw interrupt request lines |
| irq_o | output | 1 | Aggregated interrupt to the processor |
| reset_req_o | output | 1 | One-cycle system reset request |

## Verification
The hardest state to reach from the ports is an edge latch that is still set while its clear bit sits at 1. Reaching it takes a timed sequence: configure the line for edge mode, drive an active transition, wait for the synchronizer, return the input to inactive, write the clear bit, and read back before writing the zero. Directed sequences of this kind cover edge and level lines. A seeded random phase in level mode varies the inputs, enables and polarities to exercise the summary and output logic.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_ENABLE  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MODE    = 3'd1;
  localparam logic [ADDR_W-1:0] A_POL     = 3'd2;
  localparam logic [ADDR_W-1:0] A_CLEAR   = 3'd3;
  localparam logic [ADDR_W-1:0] A_SUMMARY = 3'd4;
  localparam logic [ADDR_W-1:0] A_RESET   = 3'd5;

  localparam logic [DATA_W-1:0] RESET_KEY = 32'h0000_DEAD;
  localparam logic [DATA_W-1:0] POL_INIT  = 32'h8000_0000;
endpackage

// File: rtl/irqagg_regs.sv
module irqagg_regs
  import irqagg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] enable_o,
  output logic [DATA_W-1:0] mode_o,
  output logic [DATA_W-1:0] pol_o,
  output logic [DATA_W-1:0] clear_o,
  output logic [DATA_W-1:0] dismiss_o,
  output logic              reset_req_o
);
  logic [DATA_W-1:0] enable_q, mode_q, pol_q, clear_q, dismiss_q;
  logic              reset_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q  <= '0;
      mode_q    <= '0;
      pol_q     <= POL_INIT;
      clear_q   <= '0;
      dismiss_q <= '0;
      reset_q   <= 1'b0;
    end else begin
      dismiss_q <= '0;
      reset_q   <= 1'b0;
      if (we_i) begin
        case (addr_i)
          A_ENABLE: enable_q <= wdata_i;
          A_MODE:   mode_q   <= wdata_i;
          A_POL:    pol_q    <= wdata_i;
          A_CLEAR: begin
            // bits armed by an earlier 1 are dismissed when written back to 0
            dismiss_q <= clear_q & ~wdata_i;
            clear_q   <= wdata_i;
          end
          A_RESET:  reset_q  <= (wdata_i == RESET_KEY);
          default: ;
        endcase
      end
    end
  end

  assign enable_o    = enable_q;
  assign mode_o      = mode_q;
  assign pol_o       = pol_q;
  assign clear_o     = clear_q;
  assign dismiss_o   = dismiss_q;
  assign reset_req_o = reset_q;
endmodule

// File: rtl/irqagg_line.sv
module irqagg_line #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic edge_mode_i,
  input  logic pol_i,
  input  logic dismiss_i,
  output logic status_o,
  output logic latch_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q, latch_q, samp, hit, active;

  assign samp   = sync_q[SYNC_STAGES-1];
  assign active = pol_i ? samp : ~samp;
  // compare raw samples so a polarity change alone never looks like an edge
  assign hit    = pol_i ? (samp & ~prev_q) : (~samp & prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], req_i};
      prev_q <= samp;
      if (edge_mode_i && hit) latch_q <= 1'b1;
      else if (dismiss_i)     latch_q <= 1'b0;
    end
  end

  assign status_o = edge_mode_i ? latch_q : active;
  assign latch_o  = latch_q;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqagg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RSVD_LO     = 20,
  parameter int unsigned RSVD_HI     = 30,
  parameter bit          ALT_BOARD   = 1'b0,
  parameter logic [31:0] VALID_STD   = 32'h800F_FFFF,
  parameter logic [31:0] VALID_ALT   = 32'h8000_FFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] req_i,
  output logic              irq_o,
  output logic              reset_req_o
);
  localparam logic [DATA_W-1:0] VALID = ALT_BOARD ? VALID_ALT : VALID_STD;

  logic [DATA_W-1:0] mask_w, mode_w, pol_w, clear_w, dismiss_w;
  logic [DATA_W-1:0] summary_w, latch_w;

  irqagg_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .enable_o   (mask_w),
    .mode_o     (mode_w),
    .pol_o      (pol_w),
    .clear_o    (clear_w),
    .dismiss_o  (dismiss_w),
    .reset_req_o(reset_req_o)
  );

  for (genvar i = 0; i < DATA_W; i++) begin : g_line
    if ((i >= RSVD_LO && i <= RSVD_HI) || !VALID[i]) begin : g_off
      assign summary_w[i] = 1'b0;
      assign latch_w[i]   = 1'b0;
    end else begin : g_on
      irqagg_line #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .req_i      (req_i[i]),
        .edge_mode_i(mode_w[i]),
        .pol_i      (pol_w[i]),
        .dismiss_i  (dismiss_w[i]),
        .status_o   (summary_w[i]),
        .latch_o    (latch_w[i])
      );
    end
  end

  assign irq_o = |(summary_w & mask_w);

  always_comb begin
    case (addr_i)
      A_ENABLE:  rdata_o = mask_w;
      A_MODE:    rdata_o = mode_w;
      A_POL:     rdata_o = pol_w;
      A_CLEAR:   rdata_o = clear_w;
      A_SUMMARY: rdata_o = summary_w;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker
  import irqagg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              irq_o,
  input logic              reset_req_o,
  input logic [DATA_W-1:0] mask_q,
  input logic [DATA_W-1:0] latch_q,
  input logic [DATA_W-1:0] dismiss_q
);
  assert_reset_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |=> !reset_req_o);

  assert_reset_keyed_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |-> $past(we_i && addr_i == A_RESET && wdata_i == RESET_KEY));

  assert_irq_needs_enable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask_q != '0));

  assert_dismiss_after_clear_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dismiss_q != '0) |-> $past(we_i && addr_i == A_CLEAR));

  assert_latch_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((latch_q & $past(latch_q & ~dismiss_q)) == $past(latch_q & ~dismiss_q)));
endmodule

bind irq_aggregator irqagg_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .irq_o      (irq_o),
  .reset_req_o(reset_req_o),
  .mask_q     (mask_w),
  .latch_q    (latch_w),
  .dismiss_q  (dismiss_w)
);

// File: tb/irq_aggregator_bench.sv
`timescale 1ns/1ps
module irq_aggregator_bench;
  localparam logic [31:0] VALID = 32'h800F_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] req = 32'h7FFF_FFFF;
  logic        irq, rst_req;

  int checks = 0, failures = 0, pulses = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_aggregator u_irq_aggregator (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .req_i(req), .irq_o(irq), .reset_req_o(rst_req)
  );

  always @(negedge clk) if (rst_req) pulses++;

  function automatic logic [31:0] level_sum(logic [31:0] r, logic [31:0] p);
    return ~(r ^ p) & VALID;
  endfunction

  task automatic chk(input bit ok, input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #2; d = rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, m, p, e;
    void'($urandom(32'd4242));
    settle(3); rst_n = 1'b1; settle(4);

    // R1 reset state
    rd(3'd0, d); chk(d == 0, "R1 enable", d, 0);
    rd(3'd1, d); chk(d == 0, "R1 mode", d, 0);
    rd(3'd2, d); chk(d == 32'h8000_0000, "R1 polarity", d, 32'h8000_0000);
    rd(3'd3, d); chk(d == 0, "R1 clear", d, 0);
    chk(irq == 1'b0, "R1 irq", {31'd0, irq}, 0);

    // R7 reserved lines active (pol 0, input 0) and cascade active-high
    wr(3'd0, 32'hFFFF_FFFF);
    req = 32'h81F0_0000 | 32'h000F_FFFF; // bits 20..30 mix, slots inactive, 31 high
    req[25] = 1'b0; req[21] = 1'b0;
    settle(4);
    rd(3'd4, d); chk(d == 32'h8000_0000, "R7 reserved zero", d, 32'h8000_0000);
    chk(irq == 1'b1, "R8 cascade irq", {31'd0, irq}, 1);

    // R2/R3/R7/R8 random level-mode phase
    for (int it = 0; it < 40; it++) begin
      m = $urandom(); p = $urandom();
      wr(3'd0, m); wr(3'd2, p);
      req = $urandom();
      settle(4);
      rd(3'd0, d); chk(d == m, "R2 enable readback", d, m);
      rd(3'd2, d); chk(d == p, "R2 polarity readback", d, p);
      e = level_sum(req, p);
      rd(3'd4, d); chk(d == e, "R3 level summary", d, e);
      chk(irq == |(e & m), "R8 irq", {31'd0, irq}, {31'd0, |(e & m)});
    end

    // edge line 5 (falling active), level line 2 active-low
    wr(3'd2, 32'h8000_0000);
    wr(3'd0, 32'h0000_0024);
    wr(3'd1, 32'h0000_0020);
    rd(3'd1, d); chk(d == 32'h20, "R2 mode readback", d, 32'h20);
    req = 32'h7FFF_FFFF; settle(4);
    rd(3'd4, d); chk(d == 0, "R4 idle", d, 0);
    chk(irq == 1'b0, "R8 idle irq", {31'd0, irq}, 0);
    req[5] = 1'b0; settle(4);
    rd(3'd4, d); chk(d == 32'h20, "R4 edge set", d, 32'h20);
    req[5] = 1'b1; settle(4);
    rd(3'd4, d); chk(d == 32'h20, "R4 sticky", d, 32'h20);
    chk(irq == 1'b1, "R8 edge irq", {31'd0, irq}, 1);
    wr(3'd3, 32'h20); settle(3);
    rd(3'd3, d); chk(d == 32'h20, "R2 clear readback", d, 32'h20);
    rd(3'd4, d); chk(d == 32'h20, "R5 held while clear=1", d, 32'h20);
    wr(3'd3, 32'h0); settle(3);
    rd(3'd4, d); chk(d == 0, "R5 dismissed", d, 0);
    chk(irq == 1'b0, "R5 irq after dismiss", {31'd0, irq}, 0);
    // a zero write without a preceding 1 does not dismiss
    req[5] = 1'b0; settle(4); req[5] = 1'b1; settle(3);
    wr(3'd3, 32'h0); settle(3);
    rd(3'd4, d); chk(d == 32'h20, "R5 zero alone ignored", d, 32'h20);
    wr(3'd3, 32'h20); wr(3'd3, 32'h0); settle(3);

    // R6 level line stays active through clear
    req[2] = 1'b0; settle(4);
    wr(3'd3, 32'h4); wr(3'd3, 32'h0); settle(3);
    rd(3'd4, d); chk(d == 32'h4, "R6 level survives clear", d, 32'h4);

    // R10 summary write ignored, reset reads 0
    wr(3'd4, 32'hFFFF_FFFF); settle(2);
    rd(3'd4, d); chk(d == 32'h4, "R10 summary write ignored", d, 32'h4);
    rd(3'd0, d); chk(d == 32'h24, "R10 enable untouched", d, 32'h24);

    // R9 keyed reset
    pulses = 0;
    wr(3'd5, 32'h0000_DEAE); wr(3'd5, 32'hDEAD_0000); settle(3);
    chk(pulses == 0, "R9 wrong key", pulses, 0);
    wr(3'd5, 32'h0000_DEAD); settle(3);
    chk(pulses == 1, "R9 key pulse width", pulses, 1);
    rd(3'd5, d); chk(d == 0, "R10 reset reads zero", d, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule